// File: doc/BRIEF.md
# Training Ordered-Set Polarity Detector

This block watches the decoded receive symbol stream of a serial link while the link is training. The stream arrives one symbol per clock, and each symbol has a control-character flag. Two matchers run side by side. One looks for the first training ordered set as it arrives on a correctly wired differential pair. The other looks for the same set as it arrives through a swapped pair, where the ten trailing data symbols change value. Each matcher raises its flag once eight complete sets in a row have matched.

A small polling controller uses the two flags. A start pulse moves it into its active polling state, and from then on it waits for either flag. If the normal flag fires, it clears a registered receive-polarity bit. If the inverted flag fires, it sets that bit. In both cases it then settles in a configuration state. If neither flag fires within a parameterised number of cycles (12 ms of link clock by default), it settles in an exit state that leads back to receiver detection.

Top module: `tsp_polarity_detect`

## Requirements
- R1: `sym_ready` equals `rx_en` at all times. A symbol is consumed only in a cycle where both `rx_en` and `sym_valid` are high. Symbols presented while `rx_en` is low have no effect on detection.
- R2: A set is 16 symbols long, in this order:
  - four COM symbols (data 0xBC, flag 1);
  - one symbol of data 0x00, flag 0;
  - one configuration symbol of data 0x04, flag 0 (bit 0 = reset, 0; bit 1 = loopback, 0; bit 2 = scrambling, 1);
  - ten trailing symbols of data 0x4A for the normal pattern, or 0xB5 for the inverted pattern, each with flag 0.
- R3: A detection flag goes high on the clock edge that consumes the last symbol of the 8th consecutive matching set. It stays low after only 7 such sets.
- R4: Any mismatching symbol, including one with a wrong control flag, clears that matcher's set count and its position. An asserted flag drops on the edge that consumes the mismatch.
- R5: A mismatching symbol that is itself COM counts as the first COM of a new set, so a set that starts right after a truncated one is not lost.
- R6: The flag stays high while further matching sets arrive. Idle cycles between symbols do not break a run.
- R7: `det_normal` and `det_inverted` are never high in the same cycle.
- R8: A `poll_go` pulse in the idle state enters active polling. In active polling, a high `det_normal` moves the controller to configuration with `rx_invert` = 0 on the next edge.
- R9: In active polling, a high `det_inverted` (with `det_normal` low) moves the controller to configuration with `rx_invert` = 1 on the next edge.
- R10: With no detection, `timeout_exit` rises exactly `TIMEOUT_CYCLES` edges after the edge that entered active polling.
- R11: The configuration and exit states, and `rx_invert`, hold until reset. Later detections change none of them.
- R12: While reset is asserted and just after it, `det_normal`, `det_inverted`, `rx_invert`, `in_config` and `timeout_exit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_en | input | 1 | Receive enable |
| sym_valid | input | 1 | A symbol is present on the stream |
| sym_data | input | 8 | Decoded symbol value |
| sym_is_k | input | 1 | Symbol is a control character |
| sym_ready | output | 1 | Stream acceptance, equal to rx_en |
| poll_go | input | 1 | Start pulse that enters active polling |
| det_normal | output | 1 | Eight consecutive normal-polarity sets seen |
| det_inverted | output | 1 | Eight consecutive inverted-polarity sets seen |
| rx_invert | output | 1 | Registered receive polarity choice |
| in_config | output | 1 | Controller reached the configuration state |
| timeout_exit | output | 1 | Controller timed out toward receiver detection |

## Verification
Each detection flag is due on the very edge that consumes the last symbol of the qualifying set. The polarity bit and the configuration state follow one edge after that. The timeout exit is due exactly `TIMEOUT_CYCLES` edges after the edge that took the start pulse. The bench drives and samples on falling edges. It therefore checks a flag at the falling edge right after the last symbol, checks the controller outputs one falling edge later, and checks the timeout one cycle before and exactly at the expected edge.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  localparam int SYM_W   = 8;
  localparam int SET_LEN = 16;
  localparam int COM_RUN = 4;
  localparam int D00_POS = 4;
  localparam int CFG_POS = 5;

  localparam logic CFG_RESET_BIT = 1'b0;
  localparam logic CFG_LOOP_BIT  = 1'b0;
  localparam logic CFG_SCRAM_BIT = 1'b1;

  localparam logic [SYM_W-1:0] SYM_COM        = 8'hBC;
  localparam logic [SYM_W-1:0] SYM_D00        = 8'h00;
  localparam logic [SYM_W-1:0] SYM_CFG        = {5'b0, CFG_SCRAM_BIT, CFG_LOOP_BIT, CFG_RESET_BIT};
  localparam logic [SYM_W-1:0] SYM_TRAIL_NORM = 8'h4A;
  localparam logic [SYM_W-1:0] SYM_TRAIL_INV  = 8'hB5;

  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,
    PS_ACTIVE = 2'd1,
    PS_CONFIG = 2'd2,
    PS_EXIT   = 2'd3
  } poll_st_e;
endpackage

// File: rtl/tsp_rst_sync.sv
module tsp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= 2'b00;
    else        shift_q <= {shift_q[0], 1'b1};
  end

  assign rst_n_sync = shift_q[1];
endmodule

// File: rtl/tsp_set_matcher.sv
module tsp_set_matcher
  import tsp_pkg::*;
#(
  parameter logic [SYM_W-1:0] TRAIL = SYM_TRAIL_NORM,
  parameter int               NSETS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_take,
  input  logic [SYM_W-1:0] sym_data,
  input  logic             sym_is_k,
  output logic             detected
);
  localparam int POS_W = $clog2(SET_LEN);
  localparam int CNT_W = $clog2(NSETS + 1);

  logic [POS_W-1:0] pos_q, pos_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;
  logic [SYM_W-1:0] exp_data;
  logic             exp_k;
  logic             hit;
  logic             is_com;

  // expected symbol at the current position
  always_comb begin
    if (pos_q < POS_W'(COM_RUN)) begin
      exp_data = SYM_COM;
      exp_k    = 1'b1;
    end else if (pos_q == POS_W'(D00_POS)) begin
      exp_data = SYM_D00;
      exp_k    = 1'b0;
    end else if (pos_q == POS_W'(CFG_POS)) begin
      exp_data = SYM_CFG;
      exp_k    = 1'b0;
    end else begin
      exp_data = TRAIL;
      exp_k    = 1'b0;
    end
  end

  assign hit    = (sym_data == exp_data) && (sym_is_k == exp_k);
  assign is_com = sym_is_k && (sym_data == SYM_COM);
  assign upd_en = sym_take;

  always_comb begin
    pos_d = pos_q;
    cnt_d = cnt_q;
    if (hit) begin
      if (pos_q == POS_W'(SET_LEN - 1)) begin
        pos_d = '0;
        if (cnt_q != CNT_W'(NSETS)) cnt_d = cnt_q + CNT_W'(1);
      end else begin
        pos_d = pos_q + POS_W'(1);
      end
    end else begin
      cnt_d = '0;
      pos_d = is_com ? POS_W'(1) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      cnt_q <= '0;
    end else if (upd_en) begin
      pos_q <= pos_d;
      cnt_q <= cnt_d;
    end
  end

  assign detected = (cnt_q == CNT_W'(NSETS));
endmodule

// File: rtl/tsp_poll_ctrl.sv
module tsp_poll_ctrl
  import tsp_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic poll_go,
  input  logic det_norm,
  input  logic det_inv,
  output logic rx_invert,
  output logic in_config,
  output logic timeout_exit
);
  localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);

  poll_st_e   st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic       tmr_en;
  logic       pol_q, pol_d, pol_we;

  always_comb begin
    st_d   = st_q;
    tmr_d  = tmr_q;
    tmr_en = 1'b0;
    pol_d  = pol_q;
    pol_we = 1'b0;
    case (st_q)
      PS_IDLE: begin
        if (poll_go) begin
          st_d   = PS_ACTIVE;
          tmr_d  = '0;
          tmr_en = 1'b1;
        end
      end
      PS_ACTIVE: begin
        if (det_norm) begin
          pol_d  = 1'b0;
          pol_we = 1'b1;
          st_d   = PS_CONFIG;
        end else if (det_inv) begin
          pol_d  = 1'b1;
          pol_we = 1'b1;
          st_d   = PS_CONFIG;
        end else if (tmr_q == TMR_W'(TIMEOUT_CYCLES - 1)) begin
          st_d = PS_EXIT;
        end else begin
          tmr_d  = tmr_q + TMR_W'(1);
          tmr_en = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pol_q <= 1'b0;
    else if (pol_we) pol_q <= pol_d;
  end

  assign rx_invert    = pol_q;
  assign in_config    = (st_q == PS_CONFIG);
  assign timeout_exit = (st_q == PS_EXIT);
endmodule

// File: rtl/tsp_polarity_detect.sv
module tsp_polarity_detect
  import tsp_pkg::*;
#(
  parameter int NSETS          = 8,
  parameter int TIMEOUT_CYCLES = 1500000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             sym_valid,
  input  logic [SYM_W-1:0] sym_data,
  input  logic             sym_is_k,
  output logic             sym_ready,
  input  logic             poll_go,
  output logic             det_normal,
  output logic             det_inverted,
  output logic             rx_invert,
  output logic             in_config,
  output logic             timeout_exit
);
  localparam int NUM_PAT = 2;

  logic               rst_n_int;
  logic               take;
  logic [NUM_PAT-1:0] det;

  tsp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign sym_ready = rx_en;
  assign take      = rx_en & sym_valid;

  for (genvar g = 0; g < NUM_PAT; g++) begin : g_pat
    localparam logic [SYM_W-1:0] TR = (g == 0) ? SYM_TRAIL_NORM : SYM_TRAIL_INV;
    tsp_set_matcher #(
      .TRAIL (TR),
      .NSETS (NSETS)
    ) u_match (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .sym_take (take),
      .sym_data (sym_data),
      .sym_is_k (sym_is_k),
      .detected (det[g])
    );
  end

  assign det_normal   = det[0];
  assign det_inverted = det[1];

  tsp_poll_ctrl #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .poll_go      (poll_go),
    .det_norm     (det[0]),
    .det_inv      (det[1]),
    .rx_invert    (rx_invert),
    .in_config    (in_config),
    .timeout_exit (timeout_exit)
  );
endmodule

// File: rtl/tsp_polarity_sva.sv
module tsp_polarity_sva (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic sym_valid,
  input logic det_normal,
  input logic det_inverted,
  input logic rx_invert,
  input logic in_config,
  input logic timeout_exit
);
  p_det_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(det_normal && det_inverted));

  p_norm_needs_sym_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_normal) |-> $past(rx_en && sym_valid));

  p_inv_needs_sym_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_inverted) |-> $past(rx_en && sym_valid));

  p_norm_pol_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(in_config) && $past(det_normal)) |-> !rx_invert);

  p_inv_pol_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(in_config) && !$past(det_normal)) |-> (rx_invert && $past(det_inverted)));

  p_exit_nodet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_exit) |-> (!$past(det_normal) && !$past(det_inverted)));

  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_config |=> (in_config && $stable(rx_invert)));

  p_exit_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_exit |=> (timeout_exit && !in_config && $stable(rx_invert)));
endmodule

bind tsp_polarity_detect tsp_polarity_sva u_sva (.*);

// File: tb/tb_tsp_polarity_detect.sv
module tb_tsp_polarity_detect;
  import tsp_pkg::*;

  localparam int TMO = 2000;

  logic       clk;
  logic       rst_n;
  logic       rx_en;
  logic       sym_valid;
  logic [7:0] sym_data;
  logic       sym_is_k;
  logic       sym_ready;
  logic       poll_go;
  logic       det_normal;
  logic       det_inverted;
  logic       rx_invert;
  logic       in_config;
  logic       timeout_exit;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;

  tsp_polarity_detect #(.NSETS(8), .TIMEOUT_CYCLES(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sym_valid(sym_valid),
    .sym_data(sym_data), .sym_is_k(sym_is_k), .sym_ready(sym_ready),
    .poll_go(poll_go), .det_normal(det_normal), .det_inverted(det_inverted),
    .rx_invert(rx_invert), .in_config(in_config), .timeout_exit(timeout_exit)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // vector: [15:8] number of sets, [4] inverted pattern, [1] expected det_normal, [0] expected det_inverted
  localparam logic [15:0] VEC [6] = '{16'h0802, 16'h0700, 16'h0811, 16'h0710, 16'h0A02, 16'h0911};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d, input logic k);
    @(negedge clk);
    sym_data  = d;
    sym_is_k  = k;
    sym_valid = 1'b1;
  endtask

  task automatic gap();
    @(negedge clk);
    sym_valid = 1'b0;
  endtask

  task automatic send_set(input bit inv, input bit gaps);
    for (int i = 0; i < 16; i++) begin
      if (i < 4)       put(SYM_COM, 1'b1);
      else if (i == 4) put(8'h00, 1'b0);
      else if (i == 5) put(8'h04, 1'b0);
      else             put(inv ? 8'hB5 : 8'h4A, 1'b0);
      if (gaps && (i % 5 == 0)) gap();
    end
  endtask

  task automatic send_sets(input bit inv, input int n);
    for (int s = 0; s < n; s++) send_set(inv, 1'b0);
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    rx_en     = 1'b1;
    sym_valid = 1'b0;
    sym_data  = 8'h00;
    sym_is_k  = 1'b0;
    poll_go   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_go();
    @(negedge clk);
    poll_go = 1'b1;
    @(negedge clk);
    poll_go = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R12 reset state
    rst_n = 1'b0; rx_en = 1'b0; sym_valid = 1'b0; sym_data = 8'h00; sym_is_k = 1'b0; poll_go = 1'b0;
    repeat (2) @(negedge clk);
    check("R12 outputs in reset", {27'd0, det_normal, det_inverted, rx_invert, in_config, timeout_exit}, 32'd0);
    do_reset();
    check("R12 outputs after reset", {27'd0, det_normal, det_inverted, rx_invert, in_config, timeout_exit}, 32'd0);

    // vector table: R2 patterns, R3 count boundary, R6 long runs, R7 exclusivity
    for (int v = 0; v < 6; v++) begin
      do_reset();
      send_sets(VEC[v][4], int'(VEC[v][15:8]));
      gap();
      check($sformatf("R2/R3 vec%0d det_normal", v), {31'd0, det_normal}, {31'd0, VEC[v][1]});
      check($sformatf("R2/R7 vec%0d det_inverted", v), {31'd0, det_inverted}, {31'd0, VEC[v][0]});
    end

    // R1 symbols ignored while receive disabled
    do_reset();
    rx_en = 1'b0;
    @(negedge clk);
    check("R1 ready low", {31'd0, sym_ready}, 32'd0);
    send_sets(1'b0, 8);
    gap();
    check("R1 no detect when disabled", {31'd0, det_normal}, 32'd0);
    rx_en = 1'b1;
    @(negedge clk);
    check("R1 ready high", {31'd0, sym_ready}, 32'd1);

    // R4 wrong control flag breaks a run
    do_reset();
    send_sets(1'b0, 7);
    for (int i = 0; i < 4; i++) put(SYM_COM, 1'b1);
    put(8'h00, 1'b0);
    put(8'h04, 1'b0);
    put(8'h4A, 1'b1);
    send_sets(1'b0, 7);
    gap();
    check("R4 count cleared by bad flag", {31'd0, det_normal}, 32'd0);
    send_set(1'b0, 1'b0);
    gap();
    check("R4 detect after fresh run", {31'd0, det_normal}, 32'd1);
    put(8'h4A, 1'b0);
    gap();
    check("R4 flag drops on mismatch", {31'd0, det_normal}, 32'd0);

    // R5 truncated set followed by a full run
    do_reset();
    for (int i = 0; i < 4; i++) put(SYM_COM, 1'b1);
    put(8'h00, 1'b0);
    send_sets(1'b1, 8);
    gap();
    check("R5 realign on COM", {31'd0, det_inverted}, 32'd1);

    // R6 idle cycles and disabled cycles inside a run
    do_reset();
    for (int s = 0; s < 8; s++) begin
      send_set(1'b0, 1'b1);
      @(negedge clk);
      rx_en = 1'b0; sym_valid = 1'b1; sym_data = 8'h11; sym_is_k = 1'b0;
      @(negedge clk);
      rx_en = 1'b1; sym_valid = 1'b0;
    end
    check("R6 run survives gaps", {31'd0, det_normal}, 32'd1);

    // R8 normal detection selects polarity 0
    do_reset();
    pulse_go();
    check("R8 not yet configured", {31'd0, in_config}, 32'd0);
    send_sets(1'b0, 8);
    gap();
    check("R8 det_normal", {31'd0, det_normal}, 32'd1);
    check("R8 config not before next edge", {31'd0, in_config}, 32'd0);
    gap();
    check("R8 config", {30'd0, in_config, rx_invert}, 32'd2);

    // R9 inverted detection selects polarity 1, R11 holds it
    do_reset();
    pulse_go();
    send_sets(1'b1, 8);
    gap();
    gap();
    check("R9 config inverted", {30'd0, in_config, rx_invert}, 32'd3);
    send_sets(1'b0, 8);
    gap();
    gap();
    check("R11 polarity held", {30'd0, in_config, rx_invert}, 32'd3);

    // R10 timeout, R11 exit holds
    do_reset();
    pulse_go();
    repeat (TMO - 1) @(negedge clk);
    check("R10 no exit one cycle early", {31'd0, timeout_exit}, 32'd0);
    @(negedge clk);
    check("R10 exit on time", {31'd0, timeout_exit}, 32'd1);
    send_sets(1'b1, 8);
    gap();
    gap();
    check("R11 exit held", {29'd0, timeout_exit, in_config, rx_invert}, 32'd4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule